// File: doc/BRIEF.md
# Receive Frame Length and CRC Checker

This block watches the bytes of an incoming Ethernet frame, from the first address byte through the four frame check bytes, while they are being written into a receive buffer elsewhere. It keeps a running CRC-32 and a byte count. When the frame ends, it issues a one-cycle status word. The status gives the length and flags for CRC error, runt and oversize, plus a drop decision that the buffer logic uses to keep or discard the frame.

The upper legal length is 1518 bytes, or 1522 bytes when VLAN-aware mode is set. A configuration bit decides whether frames above that limit are forwarded or discarded. A hard buffer ceiling of 1536 bytes is always enforced. Above that ceiling the count stops at 1537 and the frame is always dropped.

Top module: `rx_frame_check`

## Requirements
- R1: After reset, statusValid is low and statusCount, crcErr, runt, oversize and drop are all zero.
- R2: An accepted byte is a byte presented with byteValid high while a frame is open, or together with frameStart. The byte carrying frameEnd closes the frame. statusValid is high for exactly the one cycle after the clock edge that takes that closing byte, and statusCount equals the number of accepted bytes in the frame, with the first and last bytes included.
- R3: crcErr is set when the CRC-32 over all accepted bytes, FCS included, does not leave the residue. The CRC is processed LSB first with polynomial 0xEDB88320 and a preset of all ones. The residue in this reflected register form is 0xDEBB20E3, which is 0xC704DD7B bit-reversed. The FCS is sent as the inverted CRC, low byte first.
- R4: A frame shorter than 64 bytes sets runt and drop.
- R5: With vlanAware low, 1518 bytes is legal and 1519 bytes or more sets oversize. runt and oversize are never set together.
- R6: With vlanAware high, 1522 bytes is legal and 1523 bytes or more sets oversize.
- R7: An oversize frame of at most 1536 bytes is dropped when passOversize is low and forwarded when it is high, provided no other error is present. The configuration inputs are sampled with the closing byte.
- R8: A frame longer than 1536 bytes is always dropped, and its reported count stops at 1537.
- R9: Bytes with byteValid low, and valid bytes while no frame is open, change neither the count nor the CRC.
- R10: drop is set if crcErr or runt is set, if the frame is oversize while passOversize is low, or if the frame exceeds the buffer ceiling. Otherwise drop is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | byteData carries a byte this cycle |
| byteData | input | 8 | Received byte |
| frameStart | input | 1 | Marks the first byte of a frame |
| frameEnd | input | 1 | Marks the last byte (final FCS byte) |
| vlanAware | input | 1 | Raises the length limit to 1522 |
| passOversize | input | 1 | Forward frames above the length limit, up to the ceiling |
| statusValid | output | 1 | Status word valid for this cycle |
| statusCount | output | 11 | Frame length in bytes, saturating at 1537 |
| crcErr | output | 1 | CRC residue mismatch |
| runt | output | 1 | Frame shorter than 64 bytes |
| oversize | output | 1 | Frame above the selected length limit |
| drop | output | 1 | Frame must be discarded |

## Verification
The assertions assume that frameStart and frameEnd only count when byteValid is high. They also assume that vlanAware and passOversize are settled by the cycle of the closing byte, because the drop check compares against the value held one cycle earlier. The bench opens every frame with a single start strobe and closes it with one end strobe. It changes configuration only between frames, and it places its junk bytes and byteValid-low gaps outside the strobed positions. This way every status pulse belongs to a well-formed frame.

// File: rtl/rxchk_pkg.sv
package rxchk_pkg;

  typedef struct packed {
    logic clear;    // first byte of a new frame
    logic advance;  // byte is part of the current frame
    logic finish;   // closing byte of the frame
  } ctlStrobe_t;

  localparam logic [31:0] CRC_INIT    = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_POLY    = 32'hEDB8_8320;
  localparam logic [31:0] CRC_RESIDUE = 32'hDEBB_20E3;

  function automatic logic [31:0] crcStep(input logic [31:0] cur, input logic [7:0] data);
    logic [31:0] r;
    r = cur;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ data[i]) r = (r >> 1) ^ CRC_POLY;
      else                r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/rxchk_ctrl.sv
module rxchk_ctrl
  import rxchk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       byteValid,
  input  logic       frameStart,
  input  logic       frameEnd,
  output ctlStrobe_t strobe,
  output logic       statusValid
);

  logic inFrame;

  always_comb begin
    strobe.clear   = byteValid & frameStart;
    strobe.advance = byteValid & (inFrame | frameStart);
    strobe.finish  = byteValid & (inFrame | frameStart) & frameEnd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFrame     <= 1'b0;
      statusValid <= 1'b0;
    end else begin
      statusValid <= strobe.finish;
      if (strobe.finish)     inFrame <= 1'b0;
      else if (strobe.clear) inFrame <= 1'b1;
    end
  end

  AST_IDLE_NO_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (!inFrame && !frameStart) |-> !strobe.advance); // R9

  AST_END_GIVES_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && frameEnd && (inFrame || frameStart)) |=> (statusValid && !inFrame)); // R2

endmodule

// File: rtl/rxchk_dp.sv
module rxchk_dp
  import rxchk_pkg::*;
#(
  parameter int MIN_LEN    = 64,
  parameter int STD_MAX    = 1518,
  parameter int VLAN_EXTRA = 4,
  parameter int BUF_CAP    = 1536,
  parameter int CNT_W      = $clog2(BUF_CAP + 2)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strobe,
  input  logic [7:0]       byteData,
  input  logic             vlanAware,
  input  logic             passOversize,
  output logic [CNT_W-1:0] statusCount,
  output logic             crcErr,
  output logic             runt,
  output logic             oversize,
  output logic             drop
);

  localparam logic [CNT_W-1:0] SAT_CNT  = CNT_W'(BUF_CAP + 1);
  localparam logic [CNT_W-1:0] CAP_CNT  = CNT_W'(BUF_CAP);
  localparam logic [CNT_W-1:0] MIN_CNT  = CNT_W'(MIN_LEN);
  localparam logic [CNT_W-1:0] STD_CNT  = CNT_W'(STD_MAX);
  localparam logic [CNT_W-1:0] VLAN_CNT = CNT_W'(STD_MAX + VLAN_EXTRA);

  logic [CNT_W-1:0] runCnt, baseCnt, nextCnt, maxLen;
  logic [31:0]      runCrc, baseCrc, nextCrc;
  logic             isRunt, isOver, isCapped, isBad;

  always_comb begin
    baseCnt  = strobe.clear ? '0 : runCnt;
    baseCrc  = strobe.clear ? CRC_INIT : runCrc;
    nextCnt  = (baseCnt >= SAT_CNT) ? SAT_CNT : baseCnt + 1'b1;
    nextCrc  = crcStep(baseCrc, byteData);
    maxLen   = vlanAware ? VLAN_CNT : STD_CNT;
    isRunt   = nextCnt < MIN_CNT;
    isOver   = nextCnt > maxLen;
    isCapped = nextCnt > CAP_CNT;
    isBad    = nextCrc != CRC_RESIDUE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runCnt      <= '0;
      runCrc      <= CRC_INIT;
      statusCount <= '0;
      crcErr      <= 1'b0;
      runt        <= 1'b0;
      oversize    <= 1'b0;
      drop        <= 1'b0;
    end else begin
      if (strobe.advance) begin
        runCnt <= nextCnt;
        runCrc <= nextCrc;
      end
      if (strobe.finish) begin
        statusCount <= nextCnt;
        crcErr      <= isBad;
        runt        <= isRunt;
        oversize    <= isOver;
        drop        <= isBad | isRunt | isCapped | (isOver & ~passOversize);
      end
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    runCnt <= SAT_CNT); // R8

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.advance |=> $stable(runCnt) && $stable(runCrc)); // R9

endmodule

// File: rtl/rx_frame_check.sv
module rx_frame_check
  import rxchk_pkg::*;
#(
  parameter int MIN_LEN    = 64,
  parameter int STD_MAX    = 1518,
  parameter int VLAN_EXTRA = 4,
  parameter int BUF_CAP    = 1536,
  parameter int CNT_W      = $clog2(BUF_CAP + 2)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             byteValid,
  input  logic [7:0]       byteData,
  input  logic             frameStart,
  input  logic             frameEnd,
  input  logic             vlanAware,
  input  logic             passOversize,
  output logic             statusValid,
  output logic [CNT_W-1:0] statusCount,
  output logic             crcErr,
  output logic             runt,
  output logic             oversize,
  output logic             drop
);

  ctlStrobe_t strobe;

  rxchk_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .byteValid   (byteValid),
    .frameStart  (frameStart),
    .frameEnd    (frameEnd),
    .strobe      (strobe),
    .statusValid (statusValid)
  );

  rxchk_dp #(
    .MIN_LEN    (MIN_LEN),
    .STD_MAX    (STD_MAX),
    .VLAN_EXTRA (VLAN_EXTRA),
    .BUF_CAP    (BUF_CAP),
    .CNT_W      (CNT_W)
  ) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .byteData     (byteData),
    .vlanAware    (vlanAware),
    .passOversize (passOversize),
    .statusCount  (statusCount),
    .crcErr       (crcErr),
    .runt         (runt),
    .oversize     (oversize),
    .drop         (drop)
  );

  AST_RUNT_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (statusValid && runt) |-> drop); // R4

  AST_RUNT_NOT_OVER: assert property (@(posedge clk) disable iff (!rstN)
    (statusValid && runt) |-> !oversize); // R5

  AST_OVER_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (statusValid && oversize && !$past(passOversize)) |-> drop); // R7

  AST_CAP_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (statusValid && statusCount > CNT_W'(BUF_CAP)) |-> drop); // R8

  AST_CRC_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (statusValid && crcErr) |-> drop); // R10

endmodule

// File: tb/rx_frame_check_test.sv
module rx_frame_check_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic        byteValid, frameStart, frameEnd, vlanAware, passOversize;
  logic [7:0]  byteData;
  logic        statusValid, crcErr, runt, oversize, drop;
  logic [10:0] statusCount;

  int checks = 0;
  int fails  = 0;
  logic [7:0] frameBuf [0:1599];

  always #10 clk = ~clk; // 50 MHz

  rx_frame_check uut (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .frameStart(frameStart), .frameEnd(frameEnd), .vlanAware(vlanAware),
    .passOversize(passOversize), .statusValid(statusValid),
    .statusCount(statusCount), .crcErr(crcErr), .runt(runt),
    .oversize(oversize), .drop(drop)
  );

  function automatic logic [31:0] refCrc(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int b = 0; b < 8; b++) r = (r[0] ^ d[b]) ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Builds a frame of len bytes (FCS included), sends it, checks the status.
  task automatic runFrame(input string req, input int len, input bit badCrc,
                          input bit vlan, input bit pass, input bit gaps);
    logic [31:0] c;
    int expCnt;
    bit expRunt, expOver, expDrop;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < len - 4; i++) begin
      frameBuf[i] = 8'((i * 37 + len) & 8'hFF);
      c = refCrc(c, frameBuf[i]);
    end
    c = ~c;
    for (int k = 0; k < 4; k++) frameBuf[len - 4 + k] = c[8*k +: 8];
    if (badCrc) frameBuf[len - 2] = frameBuf[len - 2] ^ 8'h10;

    @(negedge clk);
    vlanAware = vlan; passOversize = pass;
    if (gaps) begin // junk bytes while no frame is open (R9)
      for (int j = 0; j < 3; j++) begin
        byteValid = 1'b1; byteData = 8'(8'hA5 + j); frameStart = 1'b0; frameEnd = 1'b0;
        @(negedge clk);
      end
    end
    for (int i = 0; i < len; i++) begin
      byteValid  = 1'b1;
      byteData   = frameBuf[i];
      frameStart = (i == 0);
      frameEnd   = (i == len - 1);
      if (i != len - 1) check(req, "statusValid mid-frame", int'(statusValid), 0);
      @(negedge clk);
      if (gaps && (i % 5 == 2) && i != len - 1) begin
        byteValid = 1'b0; byteData = 8'h3C; frameStart = 1'b0; frameEnd = 1'b0;
        @(negedge clk);
      end
    end
    byteValid = 1'b0; frameStart = 1'b0; frameEnd = 1'b0; byteData = 8'h00;
    expCnt  = (len > 1537) ? 1537 : len;
    expRunt = len < 64;
    expOver = len > (vlan ? 1522 : 1518);
    expDrop = badCrc || expRunt || len > 1536 || (expOver && !pass);
    check(req, "statusValid", int'(statusValid), 1);
    check(req, "statusCount", int'(statusCount), expCnt);
    check(req, "crcErr", int'(crcErr), int'(badCrc));
    check(req, "runt", int'(runt), int'(expRunt));
    check(req, "oversize", int'(oversize), int'(expOver));
    check(req, "drop", int'(drop), int'(expDrop));
    @(negedge clk);
    check(req, "statusValid one cycle", int'(statusValid), 0);
  endtask

  task automatic testReset();
    rstN = 1'b0; byteValid = 1'b0; frameStart = 1'b0; frameEnd = 1'b0;
    byteData = 8'h00; vlanAware = 1'b0; passOversize = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "statusValid", int'(statusValid), 0);
    check("R1", "statusCount", int'(statusCount), 0);
    check("R1", "flags", int'({crcErr, runt, oversize, drop}), 0);
  endtask

  initial begin
    testReset();
    runFrame("R2", 64, 0, 0, 0, 0);
    runFrame("R3", 100, 1, 0, 0, 0);
    runFrame("R4", 63, 0, 0, 0, 0);
    runFrame("R4", 20, 0, 0, 1, 0);
    runFrame("R5", 1518, 0, 0, 0, 0);
    runFrame("R5", 1519, 0, 0, 0, 0);
    runFrame("R6", 1522, 0, 1, 0, 0);
    runFrame("R6", 1523, 0, 1, 0, 0);
    runFrame("R7", 1523, 0, 1, 1, 0);
    runFrame("R7", 1536, 0, 0, 1, 0);
    runFrame("R8", 1537, 0, 0, 1, 0);
    runFrame("R8", 1600, 0, 1, 1, 0);
    runFrame("R9", 200, 0, 0, 0, 1);
    runFrame("R10", 1530, 1, 0, 1, 0);
    runFrame("R10", 300, 0, 1, 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule